// File: doc/BRIEF.md
# Memory attribute region lookup

The block holds a small table of address regions. Each region has a configuration byte and an address word. For every physical address it is given, the block reports the attributes of the region that covers that address: a 4-bit memory type code, a flag that forbids atomic operations, and whether any region matched at all. A core or interconnect uses the result to decide on cacheability, bufferability and atomic support. The block itself raises no bus faults and takes no part in cache behaviour.

Software programs the table through an indexed register port. A select bit picks either the configuration byte or the address word of one entry, and reads return the stored value one cycle after the request. An entry is either switched off or describes a naturally aligned power-of-two region. The smallest region is 4 KiB. When regions overlap, the lowest-numbered entry wins. Lookups are fully pipelined: one request can be accepted on every cycle, and its registered result appears one cycle later.

Top module: `mem_attr_lookup`

## Requirements
- R1: A lookup issued with `lk_valid` high is answered with `res_valid` high on the very next cycle. `res_valid` is low in every cycle that does not follow a lookup, and back-to-back lookups are answered in order.
- R2: A write with `reg_sel`=0 stores the configuration byte of entry `reg_idx`. The byte has four fields: bits 1:0 are the mode (0 = off, 3 = power-of-two region), bits 5:2 are the memory type, bit 6 is the atomic-disable flag, and bit 7 always reads 0. A write whose mode is 1 or 2 is stored with mode 0.
- R3: A write with `reg_sel`=1 stores all 32 bits of the address word of entry `reg_idx`. A read returns the selected word on `reg_rdata` one cycle later. A configuration byte is returned zero-extended.
- R4: An entry in mode 3 whose address word has k trailing ones in bits 29:0 covers 2^(k+3) bytes. The region starts at the address word shifted left by 2 with its low k+3 bits cleared. Bits 31:30 of the address word take no part in matching.
- R5: Address-word bits 8:0 are treated as ones when matching, so no region is smaller than 4 KiB.
- R6: When several entries match, the lowest-indexed entry supplies the type and the atomic flag, and its index appears on `res_idx`.
- R7: When no entry matches, the result is `res_hit`=0, type 0, `res_amo_dis`=1, `res_type_rsvd`=0 and `res_idx`=0.
- R8: The type is reported exactly as stored. `res_type_rsvd` is 1 when the winning entry's type is one of the unassigned codes 6, 7, 11, 12, 13 or 14, and 0 for the assigned codes 0-5, 8-10 and 15.
- R9: `res_amo_dis` equals the atomic-disable bit of the winning entry.
- R10: After reset every entry is off and reads back zero, and every lookup misses.
- R11: An entry in mode 0 never matches, whatever its address word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = configuration byte, 1 = address word |
| reg_idx | input | 4 | Entry index for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Physical address to classify |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some entry matched |
| res_idx | output | 4 | Index of the winning entry |
| res_type | output | 4 | Memory type code |
| res_amo_dis | output | 1 | Atomic operations forbidden |
| res_type_rsvd | output | 1 | Winning type code is unassigned |

## Verification
The bench probes the exact first and last byte of a region and the bytes just outside it. A design that is off by one in the trailing-ones mask would grow or shrink the region at one of those edges. An entry written with a 4 KiB base and no trailing ones shows whether the granule floor is applied: without it, the region would shrink to 8 bytes. Overlapping regions, a disabled entry at a lower index and an all-ones address word with its top bits set check priority and the ignored upper bits. A wrong scan direction or a disabled entry that still hits would return the wrong index. Writes of illegal modes and of the reserved bit are read back, and a large set of random addresses is compared against an independent range model.

// File: rtl/mal_pkg.sv
`timescale 1ns/1ps
package mal_pkg;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  typedef enum logic [3:0] {
    MT_DEV_NB     = 4'd0,
    MT_DEV_B      = 4'd1,
    MT_MEM_NC_NB  = 4'd2,
    MT_MEM_NC_B   = 4'd3,
    MT_WT_NOALLOC = 4'd4,
    MT_WT_RALLOC  = 4'd5,
    MT_RSV6       = 4'd6,
    MT_RSV7       = 4'd7,
    MT_WB_NOALLOC = 4'd8,
    MT_WB_RALLOC  = 4'd9,
    MT_WB_RWALLOC = 4'd10,
    MT_RSV11      = 4'd11,
    MT_RSV12      = 4'd12,
    MT_RSV13      = 4'd13,
    MT_RSV14      = 4'd14,
    MT_HOLE       = 4'd15
  } mem_type_e;

  // Configuration byte, MSB first: reserved, atomic disable, type, mode
  typedef struct packed {
    logic      rsvd;
    logic      amo_dis;
    mem_type_e mtype;
    logic [1:0] mode;
  } entry_cfg_t;

  // Clean a raw written byte: reserved bit cleared, illegal modes forced off
  function automatic entry_cfg_t clean_cfg(input logic [7:0] raw);
    entry_cfg_t c;
    c = entry_cfg_t'(raw);
    c.rsvd = 1'b0;
    if (c.mode != MODE_NAPOT) c.mode = MODE_OFF;
    return c;
  endfunction

  function automatic logic type_unassigned(input mem_type_e t);
    case (t)
      MT_RSV6, MT_RSV7, MT_RSV11, MT_RSV12, MT_RSV13, MT_RSV14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mal_entry_bank.sv
`timescale 1ns/1ps
module mal_entry_bank
  import mal_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int DW        = 32,
  localparam int IW       = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             sel,
  input  logic [IW-1:0]    idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output entry_cfg_t       cfg_q  [N_ENTRIES],
  output logic [DW-1:0]    addr_q [N_ENTRIES]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        cfg_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (we) begin
      if (sel) addr_q[idx] <= wdata;
      else     cfg_q[idx]  <= clean_cfg(wdata[7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (sel) rdata <= addr_q[idx];
    else rdata <= {{(DW-8){1'b0}}, cfg_q[idx]};
  end

  // R2: whatever was written, a stored mode is legal and bit 7 is clear
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> (cfg_q[$past(idx)].mode == MODE_OFF || cfg_q[$past(idx)].mode == MODE_NAPOT));
  a_r2_rsvd_clear: assert property (@(posedge clk) disable iff (rst)
    (we && !sel) |=> (cfg_q[$past(idx)].rsvd == 1'b0));
  // R3: an address write keeps every bit
  a_r3_addr_stored: assert property (@(posedge clk) disable iff (rst)
    (we && sel) |=> (addr_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mal_region_match.sv
`timescale 1ns/1ps
module mal_region_match #(
  parameter int PA_W      = 32,
  parameter int GRAN_LOG2 = 12,
  localparam int W        = PA_W - 2,
  localparam int FORCE_N  = GRAN_LOG2 - 3
) (
  input  logic         enable,
  input  logic [W-1:0] area,    // address word bits that take part in matching
  input  logic [W-1:0] word_addr,
  output logic         hit
);

  localparam logic [W-1:0] FORCE_MASK = {{(W-FORCE_N){1'b0}}, {FORCE_N{1'b1}}};
  localparam logic [W-1:0] ONE        = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] eff;
  logic [W-1:0] dont_care;
  logic [W-1:0] diff;

  always_comb begin
    eff       = area | FORCE_MASK;
    // trailing ones plus the first zero above them
    dont_care = eff ^ (eff + ONE);
    diff      = (word_addr ^ eff) & ~dont_care;
    hit       = enable && (diff == '0);
  end

endmodule

// File: rtl/mal_prio_select.sv
`timescale 1ns/1ps
module mal_prio_select #(
  parameter int N_ENTRIES = 16,
  localparam int IW       = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_ENTRIES-1:0] match,
  output logic                 any,
  output logic [IW-1:0]        win
);

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        win = IW'(i);
      end
    end
  end

  logic [N_ENTRIES-1:0] below;
  always_comb below = (N_ENTRIES'(1) << win) - N_ENTRIES'(1);

  // R6: the chosen entry matches and no lower entry does
  a_r6_winner_matches: assert property (@(posedge clk) disable iff (rst)
    any |-> match[win]);
  a_r6_none_below: assert property (@(posedge clk) disable iff (rst)
    any |-> ((match & below) == '0));
  a_r7_no_match_no_any: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |-> !any);

endmodule

// File: rtl/mem_attr_lookup.sv
`timescale 1ns/1ps
module mem_attr_lookup
  import mal_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PA_W      = 32,
  parameter int GRAN_LOG2 = 12,
  localparam int IW       = $clog2(N_ENTRIES),
  localparam int W        = PA_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic            reg_sel,
  input  logic [IW-1:0]   reg_idx,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            lk_valid,
  input  logic [PA_W-1:0] lk_addr,
  output logic            res_valid,
  output logic            res_hit,
  output logic [IW-1:0]   res_idx,
  output logic [3:0]      res_type,
  output logic            res_amo_dis,
  output logic            res_type_rsvd
);

  entry_cfg_t  cfg_q  [N_ENTRIES];
  logic [31:0] addr_q [N_ENTRIES];

  mal_entry_bank #(.N_ENTRIES(N_ENTRIES), .DW(32)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .sel   (reg_sel),
    .idx   (reg_idx),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg_q (cfg_q),
    .addr_q(addr_q)
  );

  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_match
    mal_region_match #(.PA_W(PA_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
      .enable   (cfg_q[g].mode == MODE_NAPOT),
      .area     (addr_q[g][W-1:0]),
      .word_addr(lk_addr[PA_W-1:2]),
      .hit      (match[g])
    );
  end

  logic          any;
  logic [IW-1:0] win;

  mal_prio_select #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .clk  (clk),
    .rst  (rst),
    .match(match),
    .any  (any),
    .win  (win)
  );

  entry_cfg_t win_cfg;
  always_comb win_cfg = cfg_q[win];

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_hit       <= 1'b0;
      res_idx       <= '0;
      res_type      <= '0;
      res_amo_dis   <= 1'b1;
      res_type_rsvd <= 1'b0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit       <= any;
        res_idx       <= any ? win : '0;
        res_type      <= any ? win_cfg.mtype : MT_DEV_NB;
        res_amo_dis   <= any ? win_cfg.amo_dis : 1'b1;
        res_type_rsvd <= any && type_unassigned(win_cfg.mtype);
      end
    end
  end

  // R1: one result per request, one cycle later
  a_r1_answer: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R7: a miss carries the default attributes
  a_r7_miss_default: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_type == 4'd0 && res_amo_dis && !res_type_rsvd && res_idx == '0));
  // R8: the reserved flag agrees with the reported code
  a_r8_rsvd_code: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_type_rsvd) |-> (res_hit && (res_type == 4'd6 || res_type == 4'd7 ||
                                      (res_type >= 4'd11 && res_type <= 4'd14))));

endmodule

// File: tb/mem_attr_lookup_bench.sv
`timescale 1ns/1ps
module mem_attr_lookup_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_amo_dis, res_type_rsvd;
  logic [3:0]  res_idx, res_type;

  always #4 clk = ~clk;

  mem_attr_lookup u_mem_attr_lookup (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_type(res_type),
    .res_amo_dis(res_amo_dis), .res_type_rsvd(res_type_rsvd)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
    logic [3:0]  idx;
    logic [3:0]  typ;
    logic        amo;
    logic        rsvd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [7:0]  sh_cfg  [16];
  logic [31:0] sh_addr [16];

  function automatic exp_t model(input logic [31:0] a);
    exp_t e;
    e = '0;
    e.addr = a;
    e.amo  = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      if (sh_cfg[i][1:0] == 2'd3) begin
        logic [29:0] r;
        int k;
        longint unsigned size, base;
        r = sh_addr[i][29:0] | 30'h1FF;
        k = 0;
        while (k < 30 && r[k]) k++;
        size = 64'd1 << (k + 3);
        base = {32'd0, sh_addr[i][29:0], 2'b00} & ~(size - 64'd1);
        if ({32'd0, a} >= base && {32'd0, a} < base + size) begin
          logic [3:0] t;
          t = sh_cfg[i][5:2];
          e.hit  = 1'b1;
          e.idx  = 4'(i);
          e.typ  = t;
          e.amo  = sh_cfg[i][6];
          e.rsvd = (t == 4'd6 || t == 4'd7 || (t >= 4'd11 && t <= 4'd14));
        end
      end
    end
    return e;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the expected item whenever a result appears
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected result", 64'(res_hit), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({res_hit, res_idx, res_type, res_amo_dis, res_type_rsvd} ==
              {e.hit, e.idx, e.typ, e.amo, e.rsvd},
              $sformatf("%s addr=%h", t, e.addr),
              64'({res_hit, res_idx, res_type, res_amo_dis, res_type_rsvd}),
              64'({e.hit, e.idx, e.typ, e.amo, e.rsvd}));
      end
    end
  end

  task automatic lookup(input logic [31:0] a, input string tag);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_valid = 1'b0;
      reg_we   = 1'b0;
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] idx, input logic [31:0] d);
    logic [7:0] c;
    @(negedge clk);
    lk_valid  = 1'b0;
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_idx   = idx;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel) sh_addr[idx] = d;
    else begin
      c = d[7:0];
      c[7] = 1'b0;
      if (c[1:0] != 2'd3) c[1:0] = 2'd0;
      sh_cfg[idx] = c;
    end
  endtask

  task automatic rd(input logic sel, input logic [3:0] idx, input logic [31:0] expv, input string tag);
    @(negedge clk);
    lk_valid = 1'b0;
    reg_sel  = sel;
    reg_idx  = idx;
    @(negedge clk);
    check(reg_rdata == expv, tag, 64'(reg_rdata), 64'(expv));
  endtask

  bit done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      sh_cfg[i]  = '0;
      sh_addr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    rd(1'b0, 4'd0, 32'h0, "R10 cfg0 after reset");
    rd(1'b1, 4'd5, 32'h0, "R10 addr5 after reset");
    check(res_valid == 1'b0, "R1 idle after reset", 64'(res_valid), 64'd0);
    lookup(32'h8000_0000, "R10 miss after reset");
    lookup(32'h0000_0000, "R7 miss default");
    idle(3);

    // R2: illegal mode and reserved bit
    wr(1'b0, 4'd4, 32'h0000_000D);
    rd(1'b0, 4'd4, 32'h0000_000C, "R2 mode 1 stored as off");
    wr(1'b0, 4'd0, 32'hFFFF_FFDB);
    rd(1'b0, 4'd0, 32'h0000_005B, "R2 bit7 reads zero");
    wr(1'b1, 4'd0, 32'h0000_0400);
    rd(1'b1, 4'd0, 32'h0000_0400, "R3 addr readback");

    // R5: 4 KiB floor, R8 reserved type 6
    lookup(32'h0000_1000, "R5 granule first byte");
    lookup(32'h0000_1FFF, "R5 granule last byte");
    lookup(32'h0000_2000, "R5 just above granule");
    lookup(32'h0000_0FFF, "R5 just below granule");
    idle(3);

    // R4, R9: 64 KiB region, type 9, atomics allowed
    wr(1'b1, 4'd2, 32'h2000_1FFF);
    wr(1'b0, 4'd2, 32'h0000_0027);
    lookup(32'h8000_0000, "R4 region base");
    lookup(32'h8000_FFFF, "R4 region last byte");
    lookup(32'h8001_0000, "R4 above region");
    lookup(32'h7FFF_FFFC, "R4 below region");
    idle(3);

    // R6: overlapping 1 MiB region, type 15
    wr(1'b1, 4'd5, 32'h2001_FFFF);
    wr(1'b0, 4'd5, 32'h0000_007F);
    lookup(32'h8000_1000, "R6 lower index wins");
    lookup(32'h8008_0000, "R6 outer region only");
    lookup(32'h800F_FFFF, "R4 outer last byte");
    lookup(32'h8010_0000, "R4 outer above");
    idle(3);

    // R11: disabled lower entry covering everything
    wr(1'b1, 4'd1, 32'h3FFF_FFFF);
    wr(1'b0, 4'd1, 32'h0000_000C);
    lookup(32'h4000_0000, "R11 disabled entry ignored");
    lookup(32'h8000_0004, "R11 disabled lower entry");
    idle(3);

    // R3/R4: all-ones word, top bits ignored; type 12 reserved
    wr(1'b1, 4'd9, 32'hFFFF_FFFF);
    rd(1'b1, 4'd9, 32'hFFFF_FFFF, "R3 all bits stored");
    wr(1'b0, 4'd9, 32'h0000_0073);
    lookup(32'h4000_0000, "R8 reserved type 12");
    lookup(32'hFFFF_FFFF, "R4 whole space top byte");
    lookup(32'h0000_1800, "R6 entry0 over entry9");
    idle(3);

    // R2/R11: mode 2 write turns entry 2 off
    wr(1'b0, 4'd2, 32'h0000_0026);
    rd(1'b0, 4'd2, 32'h0000_0024, "R2 mode 2 stored as off");
    lookup(32'h8000_0000, "R11 entry2 now off");
    idle(3);

    // Random traffic against the model, back to back
    for (int n = 0; n < 150; n++) begin
      logic [31:0] a;
      a = $urandom();
      if (n % 3 == 0) a = 32'h8000_0000 | (a & 32'h001F_FFFF);
      if (n % 5 == 0) a = a & 32'h0000_3FFF;
      lookup(a, "R6 random lookup");
    end
    idle(4);
    check(exp_q.size() == 0, "R1 all lookups answered", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule